// File: doc/BRIEF.md
# Configurable registered command buffer

This block registers the command and address lines that a memory controller sends to a registered memory module. It captures a bank of data lanes and three control signals (rank select, termination enable, clock enable) on each rising clock edge. A two-bit static setting picks one of three arrangements. The first is a wide arrangement with 25 lanes and one output per lane. The other two are narrow arrangements with 14 lanes, where every registered lane drives a primary copy and a secondary copy. The two narrow arrangements differ in which lanes carry data.

Two active-low select inputs decide whether the data lanes update. When both selects are high at an edge, the data outputs keep their contents. The control outputs register on every edge regardless of the selects. An asynchronous active-low reset clears the whole block and has priority over everything else. Lane i of `d_in` corresponds to the input numbered i+1 in the module's lane numbering. Unused lanes and disabled outputs always read 0.

Top module: `cmd_reg_buffer`

## Requirements
- R1: While `rst_n` is low, every output is 0, starting at the moment reset asserts and without waiting for a clock edge, whatever the other inputs do.
- R2: On every edge with reset released, `cs_q` takes `cs_dimm_n`, `odt_q` takes `odt_in` and `cke_q` takes `cke_in`, for all four select combinations.
- R3: When `cs_dimm_n` or `cs_rank_n` is low at an edge, each data lane that is used in the current arrangement loads its `d_in` bit. Lanes that are not used load 0.
- R4: When both `cs_dimm_n` and `cs_rank_n` are high at an edge, the stored data lanes keep their previous contents.
- R5: Wide arrangement (`cfg_dual`=0, `cfg_alt` ignored): lanes 0, 3 and 6 are unused and read 0, and every bit of `q_b` is 0.
- R6: Narrow arrangement A (`cfg_dual`=1, `cfg_alt`=0): lanes 1, 2, 4, 5 and 7 to 13 are used. `q_b[i]` equals `q_a[i]` for i < 14, and `q_a` bits 14 to 24 are 0.
- R7: Narrow arrangement B (`cfg_dual`=1, `cfg_alt`=1): lanes 0 to 5, 7 to 9, 11 and 12 are used. Lanes 10 and 13 read 0, and `q_b` duplicates `q_a[13:0]`.
- R8: The arrangement is captured at each edge and applies to the outputs from that edge on. A change does not alter the stored lane contents: when a switch happens during a held (R4) edge, the outputs show the stored contents masked by the new arrangement.
- R9: After reset is released, with the data and control inputs held at 0, every output stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg_dual | input | 1 | 0: wide one-copy arrangement, 1: narrow two-copy arrangement |
| cfg_alt | input | 1 | Selects narrow arrangement B when high |
| cs_dimm_n | input | 1 | Active-low select, also the source of `cs_q` |
| cs_rank_n | input | 1 | Active-low select used only for gating |
| odt_in | input | 1 | Termination enable input |
| cke_in | input | 1 | Clock enable input |
| d_in | input | 25 | Data lanes |
| q_a | output | 25 | Primary registered data copy |
| q_b | output | 14 | Secondary registered data copy |
| cs_q | output | 1 | Registered select |
| odt_q | output | 1 | Registered termination enable |
| cke_q | output | 1 | Registered clock enable |

## Verification
A wrong stored lane shows on `q_a` one edge after the load, and it stays there through every held edge until the selects next open the gate. Because of this, a fault in the gating is easiest to see after several held cycles followed by a switch of arrangement. A wrong captured arrangement shows up at once on the next edge: a lane that should be masked carries data, or the secondary copy differs from the primary copy. A reset fault shows on the ports within one time step of the falling edge of `rst_n`, without waiting for a clock.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DUAL_A = 2'd1,
    MODE_DUAL_B = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic dual, input logic alt);
    if (!dual)   return MODE_SINGLE;
    else if (alt) return MODE_DUAL_B;
    else          return MODE_DUAL_A;
  endfunction

  // Lane occupancy per arrangement. The control positions remove lanes
  // from the data set, and the narrow arrangements cut the set to `narrow` lanes.
  function automatic logic lane_used(input mode_e m, input int lane,
                                     input int narrow, input int cke_l,
                                     input int odt_l, input int cs_l,
                                     input int alt_odt_l, input int alt_cke_l);
    logic fixed_ctl;
    fixed_ctl = (lane == cke_l) || (lane == odt_l);
    case (m)
      MODE_SINGLE: return !fixed_ctl && (lane != cs_l);
      MODE_DUAL_A: return (lane < narrow) && !fixed_ctl && (lane != cs_l);
      MODE_DUAL_B: return (lane < narrow) && (lane != cs_l) &&
                          (lane != alt_odt_l) && (lane != alt_cke_l);
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmdbuf_mode_reg.sv
module cmdbuf_mode_reg
  import cmdbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_now,
  output mode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SINGLE;
    else        mode_q <= mode_now;
  end

endmodule

// File: rtl/cmdbuf_ctrl_reg.sv
module cmdbuf_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_dimm_n,
  input  logic odt_in,
  input  logic cke_in,
  output logic cs_q,
  output logic odt_q,
  output logic cke_q
);

  // Never gated by the selects.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      odt_q <= 1'b0;
      cke_q <= 1'b0;
    end else begin
      cs_q  <= cs_dimm_n;
      odt_q <= odt_in;
      cke_q <= cke_in;
    end
  end

endmodule

// File: rtl/cmdbuf_data_bank.sv
module cmdbuf_data_bank
  import cmdbuf_pkg::*;
#(
  parameter int WIDE      = 25,
  parameter int NARROW    = 14,
  parameter int CKE_LANE  = 0,
  parameter int ODT_LANE  = 3,
  parameter int CS_LANE   = 6,
  parameter int ALT_ODT   = 10,
  parameter int ALT_CKE   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  mode_e           mode_now,
  input  mode_e           mode_q,
  input  logic [WIDE-1:0] d_in,
  output logic [WIDE-1:0] q_a,
  output logic [NARROW-1:0] q_b
);

  logic [WIDE-1:0] store_q;

  for (genvar i = 0; i < WIDE; i++) begin : g_lane
    logic use_now, use_out;
    assign use_now = lane_used(mode_now, i, NARROW, CKE_LANE, ODT_LANE,
                               CS_LANE, ALT_ODT, ALT_CKE);
    assign use_out = lane_used(mode_q, i, NARROW, CKE_LANE, ODT_LANE,
                               CS_LANE, ALT_ODT, ALT_CKE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       store_q[i] <= 1'b0;
      else if (load_en) store_q[i] <= d_in[i] & use_now;
    end

    assign q_a[i] = store_q[i] & use_out;
  end

  for (genvar j = 0; j < NARROW; j++) begin : g_copy
    assign q_b[j] = (mode_q != MODE_SINGLE) & q_a[j];
  end

endmodule

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer
  import cmdbuf_pkg::*;
#(
  parameter int WIDE   = 25,
  parameter int NARROW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_alt,
  input  logic              cs_dimm_n,
  input  logic              cs_rank_n,
  input  logic              odt_in,
  input  logic              cke_in,
  input  logic [WIDE-1:0]   d_in,
  output logic [WIDE-1:0]   q_a,
  output logic [NARROW-1:0] q_b,
  output logic              cs_q,
  output logic              odt_q,
  output logic              cke_q
);

  mode_e mode_now, mode_q;
  logic  load_en;

  assign mode_now = decode_mode(cfg_dual, cfg_alt);
  assign load_en  = !(cs_dimm_n && cs_rank_n);

  cmdbuf_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_now(mode_now), .mode_q(mode_q)
  );

  cmdbuf_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_dimm_n(cs_dimm_n), .odt_in(odt_in),
    .cke_in(cke_in), .cs_q(cs_q), .odt_q(odt_q), .cke_q(cke_q)
  );

  cmdbuf_data_bank #(.WIDE(WIDE), .NARROW(NARROW)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .mode_now(mode_now),
    .mode_q(mode_q), .d_in(d_in), .q_a(q_a), .q_b(q_b)
  );

endmodule

// File: rtl/cmd_reg_buffer_chk.sv
module cmd_reg_buffer_chk #(
  parameter int WIDE   = 25,
  parameter int NARROW = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_dual,
  input logic              cfg_alt,
  input logic              cs_dimm_n,
  input logic              cs_rank_n,
  input logic              odt_in,
  input logic              cke_in,
  input logic [WIDE-1:0]   d_in,
  input logic [WIDE-1:0]   q_a,
  input logic [NARROW-1:0] q_b,
  input logic              cs_q,
  input logic              odt_q,
  input logic              cke_q
);

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && !cs_q && !odt_q && !cke_q));

  p_ctrl_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cs_q == $past(cs_dimm_n) && odt_q == $past(odt_in) &&
                      cke_q == $past(cke_in)));

  p_top_lane_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cs_dimm_n) && !$past(cfg_dual))
      |-> q_a[WIDE-1] == $past(d_in[WIDE-1]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cs_dimm_n && cs_rank_n && $stable({cfg_dual, cfg_alt}))
      |=> ($stable(q_a) && $stable(q_b)));

  p_single_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_dual))
      |-> (q_b == '0 && !q_a[0] && !q_a[3] && !q_a[6]));

  p_alt_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_dual) && $past(cfg_alt))
      |-> (!q_a[10] && !q_a[13] && q_a[WIDE-1:NARROW] == '0));

endmodule

bind cmd_reg_buffer cmd_reg_buffer_chk #(.WIDE(WIDE), .NARROW(NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_alt(cfg_alt),
  .cs_dimm_n(cs_dimm_n), .cs_rank_n(cs_rank_n), .odt_in(odt_in),
  .cke_in(cke_in), .d_in(d_in), .q_a(q_a), .q_b(q_b), .cs_q(cs_q),
  .odt_q(odt_q), .cke_q(cke_q)
);

// File: tb/test_cmd_reg_buffer.sv
module test_cmd_reg_buffer;

  localparam int WIDE   = 25;
  localparam int NARROW = 14;

  typedef struct {
    logic [WIDE-1:0]   qa;
    logic [NARROW-1:0] qb;
    logic              cs, odt, cke;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cfg_dual = 1'b0, cfg_alt = 1'b0;
  logic cs_dimm_n = 1'b1, cs_rank_n = 1'b1;
  logic odt_in = 1'b0, cke_in = 1'b0;
  logic [WIDE-1:0]   d_in = '0;
  logic [WIDE-1:0]   q_a;
  logic [NARROW-1:0] q_b;
  logic cs_q, odt_q, cke_q;

  int total = 0;
  int bad   = 0;
  exp_t sb[$];

  // Reference state
  logic [WIDE-1:0] m_store = '0;
  logic [1:0]      m_mode  = 2'b00;   // {dual, alt}
  logic            m_cs = 0, m_odt = 0, m_cke = 0;

  always #10 clk = ~clk;

  cmd_reg_buffer #(.WIDE(WIDE), .NARROW(NARROW)) i_cmd_reg_buffer (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_alt(cfg_alt),
    .cs_dimm_n(cs_dimm_n), .cs_rank_n(cs_rank_n), .odt_in(odt_in),
    .cke_in(cke_in), .d_in(d_in), .q_a(q_a), .q_b(q_b), .cs_q(cs_q),
    .odt_q(odt_q), .cke_q(cke_q)
  );

  function automatic logic [WIDE-1:0] mask_of(input logic dual, input logic alt);
    if (!dual)   return 25'h1FF_FFB6;   // all but lanes 0,3,6
    else if (alt) return 25'h000_1BBF;  // lanes 0-5,7-9,11,12
    else          return 25'h000_3FB6;  // lanes 1,2,4,5,7-13
  endfunction

  function automatic exp_t model_out(input string tag);
    exp_t e;
    e.qa  = m_store & mask_of(m_mode[1], m_mode[0]);
    e.qb  = m_mode[1] ? e.qa[NARROW-1:0] : '0;
    e.cs  = m_cs; e.odt = m_odt; e.cke = m_cke;
    e.tag = tag;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    total++;
    if (q_a !== e.qa || q_b !== e.qb || cs_q !== e.cs ||
        odt_q !== e.odt || cke_q !== e.cke) begin
      bad++;
      $display("FAIL %s: got qa=%h qb=%h cs=%b odt=%b cke=%b exp qa=%h qb=%h cs=%b odt=%b cke=%b",
               e.tag, q_a, q_b, cs_q, odt_q, cke_q,
               e.qa, e.qb, e.cs, e.odt, e.cke);
    end
  endtask

  // Monitor: one expected item per edge, compared mid-cycle.
  always @(negedge clk) begin
    if (sb.size() > 0) compare(sb.pop_front());
  end

  // Driver: called at a falling edge, applies inputs, models the edge.
  task automatic step(input logic [WIDE-1:0] d, input logic dcs, input logic csr,
                      input logic odt, input logic cke, input logic dual,
                      input logic alt, input string tag);
    d_in = d; cs_dimm_n = dcs; cs_rank_n = csr; odt_in = odt; cke_in = cke;
    cfg_dual = dual; cfg_alt = alt;
    @(posedge clk);
    if (!(dcs && csr)) m_store = d & mask_of(dual, alt);
    m_mode = {dual, alt};
    m_cs = dcs; m_odt = odt; m_cke = cke;
    sb.push_back(model_out(tag));
    @(negedge clk);
  endtask

  task automatic reset_mid(input string tag);
    exp_t z;
    #4 rst_n = 1'b0;
    #1;
    m_store = '0; m_mode = 2'b00; m_cs = 0; m_odt = 0; m_cke = 0;
    z = model_out(tag);
    compare(z);                               // R1: immediate clear
    d_in = '1; cs_dimm_n = 1'b0; cs_rank_n = 1'b0; odt_in = 1'b1; cke_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare(z);                               // R1: clock ignored in reset
    #2 rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog: got running exp finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [WIDE-1:0] r;
    #1 rst_n = 1'b0;
    @(negedge clk);
    compare(model_out("R1 reset state"));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: zero inputs after release keep outputs at 0
    for (int k = 0; k < 3; k++) step('0, 1'b0, 1'b0, 1'b0, 1'b0, k[0], k[1], "R9 quiet after reset");

    // Wide arrangement, all select combinations (R2 R3 R4 R5)
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        r = WIDE'($urandom);
        step(r, c[1], c[0], k[0], ~k[0], 1'b0, k[1], (c == 3) ? "R4 hold wide" : "R3 R5 load wide");
      end
    end
    step('1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 unused lanes zero, alt ignored");
    step('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2 R4 ctrl register while held");

    // Narrow A
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        r = WIDE'($urandom);
        step(r, c[0], c[1], ~k[0], k[1], 1'b1, 1'b0, (c == 3) ? "R4 hold A" : "R6 load A");
      end
    end
    step('1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 all ones A");

    // Narrow B
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        r = WIDE'($urandom);
        step(r, c[1], c[0], k[0], k[0], 1'b1, 1'b1, (c == 3) ? "R4 hold B" : "R7 load B");
      end
    end
    step('1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7 all ones B");

    // R8: switch arrangement while held
    step('1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 load wide");
    step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 held switch to A");
    step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 held switch to B");
    step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 held back to wide");
    r = WIDE'($urandom);
    step(r, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R8 load B");
    step('0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 held switch B to wide");

    // Reset in the middle of a sequence
    step('1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 preload before reset");
    reset_mid("R1 reset mid sequence");
    step('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 quiet after mid reset");
    step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 quiet held");
    r = WIDE'($urandom);
    step(r, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3 reload after reset");

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule